// File: doc/BRIEF.md
# Serially Loaded Clock Configuration Register

This block keeps the 89-bit setup word of a clock-conditioning circuit. The word arrives one bit per edge of a serial clock while a shift command is held high. It moves along a shadow chain whose far end is visible as a serial output, so several such chains can be cascaded or read back. A separate update command copies the shadow chain into an active register in one edge. The clock logic downstream therefore never sees a half-loaded word.

A mode input picks which word the downstream logic uses. With mode low it uses the active register. With mode high it uses a fixed built-in image that stands in for non-volatile settings. The chosen word is driven out whole, and also split into decoded parallel fields: the dividers, the output selects, the delays and the flags. Bit positions that belong to no field are forced to zero whenever the active register loads.

Top module: `cfg_serial_chain`

## Requirements
- R1: While rst_ni is low, the shadow chain is all zeros, so sdata_o is 0, and the active register holds the built-in image.
- R2: On each rising clk_i edge with shift_i high, sdata_i enters chain bit 0 and every other chain bit moves up one index, toward bit 88.
- R3: sdata_o always shows chain bit 88. A bit captured on one shifting edge appears on sdata_o after the 88th shifting edge that follows it. A word is therefore sent bit 88 first, and 89 shifting edges load it completely.
- R4: On an edge with shift_i low, the chain keeps its value whatever sdata_i does.
- R5: On an edge with update_i high and shift_i low, the active register takes the chain contents. Shifting alone never changes the active register.
- R6: On an edge where shift_i and update_i are both high, the shift is performed and the active register keeps its old value.
- R7: mode_i is combinational. With mode_i at 0, image_o and the field outputs follow the active register. With mode_i at 1, they follow the built-in image.
- R8: The fields are decoded from image_o as follows. in_div_o is [6:0] and fb_div_o is [13:7]. out_div_o channels 0, 1 and 2 are [18:14], [23:19] and [28:24]. out_mux_o channels 0, 1 and 2 are [31:29], [34:32] and [37:35]. fb_sel_o is [39:38] and fb_dly_o is [44:40]. ext_dly_sel_o is [45]. out_dly_o channels 0, 1 and 2 are [50:46], [55:51] and [60:56]. vco_sel_o is [76:74] and rst_en_o is [80]. half_div_o channels 0, 1 and 2 are bits 84, 85 and 86. gmux_cfg_o is [88:87].
- R9: Bits 61 to 73, 77 to 79 and 81 to 83 read as 0 in the active register after every update, whatever was shifted into them.
- R10: The built-in image is zero except for these fields: in_div 7'h12, fb_div 7'h12, out_div channel 0 = 1, out_mux channel 0 = 4, fb_sel 1, ext_dly_sel 1, out_dly channel 0 = 3, out_dly channel 1 = 31, and rst_en 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data in |
| shift_i | input | 1 | Shift command |
| update_i | input | 1 | Copy chain to active register |
| mode_i | input | 1 | 0 = active register, 1 = built-in image |
| sdata_o | output | 1 | Last chain bit |
| image_o | output | 89 | Selected configuration word |
| in_div_o | output | 7 | Input divider |
| fb_div_o | output | 7 | Feedback divider |
| out_div_o | output | 3x5 | Output dividers, channel 0..2 |
| out_mux_o | output | 3x3 | Output source selects |
| fb_sel_o | output | 2 | Feedback source select |
| fb_dly_o | output | 5 | Feedback delay |
| ext_dly_sel_o | output | 1 | Extra delay select |
| out_dly_o | output | 3x5 | Output delays |
| vco_sel_o | output | 3 | VCO range select |
| rst_en_o | output | 1 | Reset enable |
| half_div_o | output | 3 | Half-step divide flags |
| gmux_cfg_o | output | 2 | Glitchless mux configuration |

## Verification
A shift and an update can fall on the same serial clock edge. The bench provokes this by holding update_i high during a single shifting edge. It then confirms that the selected word has not changed. A later plain update must show the chain moved by exactly that one bit, which proves the shift was not lost to the update. A second overlap, shifting while the mode selects the built-in image, is judged by checking that the fields stay at the built-in values during the load.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  localparam int CFG_W    = 89;
  localparam int NCH      = 3;
  localparam int IDIV_W   = 7;
  localparam int ODIV_W   = 5;
  localparam int OMUX_W   = 3;
  localparam int DLY_W    = 5;
  localparam int FBSEL_W  = 2;
  localparam int VCO_W    = 3;
  localparam int GMUX_W   = 2;

  localparam int IN_DIV_LSB  = 0;
  localparam int FB_DIV_LSB  = 7;
  localparam int OUT_DIV_LSB = 14;
  localparam int OUT_MUX_LSB = 29;
  localparam int FB_SEL_LSB  = 38;
  localparam int FB_DLY_LSB  = 40;
  localparam int XDLY_BIT    = 45;
  localparam int OUT_DLY_LSB = 46;
  localparam int VCO_LSB     = 74;
  localparam int RST_EN_BIT  = 80;
  localparam int HALF_LSB    = 84;
  localparam int GMUX_LSB    = 87;

  function automatic logic [CFG_W-1:0] build_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    for (int i = 0; i < IDIV_W; i++) begin
      m[IN_DIV_LSB+i] = 1'b1;
      m[FB_DIV_LSB+i] = 1'b1;
    end
    for (int c = 0; c < NCH; c++) begin
      for (int i = 0; i < ODIV_W; i++) m[OUT_DIV_LSB+c*ODIV_W+i] = 1'b1;
      for (int i = 0; i < OMUX_W; i++) m[OUT_MUX_LSB+c*OMUX_W+i] = 1'b1;
      for (int i = 0; i < DLY_W; i++)  m[OUT_DLY_LSB+c*DLY_W+i]  = 1'b1;
      m[HALF_LSB+c] = 1'b1;
    end
    for (int i = 0; i < FBSEL_W; i++) m[FB_SEL_LSB+i] = 1'b1;
    for (int i = 0; i < DLY_W; i++)   m[FB_DLY_LSB+i] = 1'b1;
    for (int i = 0; i < VCO_W; i++)   m[VCO_LSB+i]    = 1'b1;
    for (int i = 0; i < GMUX_W; i++)  m[GMUX_LSB+i]   = 1'b1;
    m[XDLY_BIT]   = 1'b1;
    m[RST_EN_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [CFG_W-1:0] build_default();
    logic [CFG_W-1:0] d;
    d = '0;
    d[IN_DIV_LSB +: IDIV_W]            = 7'h12;
    d[FB_DIV_LSB +: IDIV_W]            = 7'h12;
    d[OUT_DIV_LSB +: ODIV_W]           = 5'd1;
    d[OUT_MUX_LSB +: OMUX_W]           = 3'd4;
    d[FB_SEL_LSB +: FBSEL_W]           = 2'd1;
    d[XDLY_BIT]                        = 1'b1;
    d[OUT_DLY_LSB +: DLY_W]            = 5'd3;
    d[OUT_DLY_LSB+DLY_W +: DLY_W]      = 5'd31;
    d[RST_EN_BIT]                      = 1'b1;
    return d;
  endfunction

  localparam logic [CFG_W-1:0] USED_MASK   = build_mask();
  localparam logic [CFG_W-1:0] DEFAULT_IMG = build_default();
endpackage

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int W = 89
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         sdata_i,
  output logic [W-1:0] chain_o,
  output logic         sdata_o
);
  logic [W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chain_q <= '0;
    else if (shift_i) chain_q <= {chain_q[W-2:0], sdata_i};
  end

  assign chain_o = chain_q;
  assign sdata_o = chain_q[W-1];
endmodule

// File: rtl/cfg_active_reg.sv
module cfg_active_reg #(
  parameter int           W       = 89,
  parameter logic [W-1:0] MASK    = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] image_i,
  output logic [W-1:0] active_o
);
  logic [W-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= RST_VAL;
    else if (load_i) active_q <= image_i & MASK;
  end

  assign active_o = active_q;
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
  import cfg_chain_pkg::*;
(
  input  logic [CFG_W-1:0]             image_i,
  output logic [IDIV_W-1:0]            in_div_o,
  output logic [IDIV_W-1:0]            fb_div_o,
  output logic [NCH-1:0][ODIV_W-1:0]   out_div_o,
  output logic [NCH-1:0][OMUX_W-1:0]   out_mux_o,
  output logic [FBSEL_W-1:0]           fb_sel_o,
  output logic [DLY_W-1:0]             fb_dly_o,
  output logic                         ext_dly_sel_o,
  output logic [NCH-1:0][DLY_W-1:0]    out_dly_o,
  output logic [VCO_W-1:0]             vco_sel_o,
  output logic                         rst_en_o,
  output logic [NCH-1:0]               half_div_o,
  output logic [GMUX_W-1:0]            gmux_cfg_o
);
  assign in_div_o      = image_i[IN_DIV_LSB +: IDIV_W];
  assign fb_div_o      = image_i[FB_DIV_LSB +: IDIV_W];
  assign fb_sel_o      = image_i[FB_SEL_LSB +: FBSEL_W];
  assign fb_dly_o      = image_i[FB_DLY_LSB +: DLY_W];
  assign ext_dly_sel_o = image_i[XDLY_BIT];
  assign vco_sel_o     = image_i[VCO_LSB +: VCO_W];
  assign rst_en_o      = image_i[RST_EN_BIT];
  assign gmux_cfg_o    = image_i[GMUX_LSB +: GMUX_W];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign out_div_o[c]  = image_i[OUT_DIV_LSB + c*ODIV_W +: ODIV_W];
    assign out_mux_o[c]  = image_i[OUT_MUX_LSB + c*OMUX_W +: OMUX_W];
    assign out_dly_o[c]  = image_i[OUT_DLY_LSB + c*DLY_W +: DLY_W];
    assign half_div_o[c] = image_i[HALF_LSB + c];
  end
endmodule

// File: rtl/cfg_serial_chain.sv
module cfg_serial_chain
  import cfg_chain_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sdata_i,
  input  logic                         shift_i,
  input  logic                         update_i,
  input  logic                         mode_i,
  output logic                         sdata_o,
  output logic [CFG_W-1:0]             image_o,
  output logic [IDIV_W-1:0]            in_div_o,
  output logic [IDIV_W-1:0]            fb_div_o,
  output logic [NCH-1:0][ODIV_W-1:0]   out_div_o,
  output logic [NCH-1:0][OMUX_W-1:0]   out_mux_o,
  output logic [FBSEL_W-1:0]           fb_sel_o,
  output logic [DLY_W-1:0]             fb_dly_o,
  output logic                         ext_dly_sel_o,
  output logic [NCH-1:0][DLY_W-1:0]    out_dly_o,
  output logic [VCO_W-1:0]             vco_sel_o,
  output logic                         rst_en_o,
  output logic [NCH-1:0]               half_div_o,
  output logic [GMUX_W-1:0]            gmux_cfg_o
);
  logic [CFG_W-1:0] chain_q;
  logic [CFG_W-1:0] active_q;
  logic             load;

  // shift has priority over update on a shared edge
  assign load = update_i & ~shift_i;

  cfg_shift_chain #(.W(CFG_W)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_i),
    .sdata_i (sdata_i),
    .chain_o (chain_q),
    .sdata_o (sdata_o)
  );

  cfg_active_reg #(
    .W       (CFG_W),
    .MASK    (USED_MASK),
    .RST_VAL (DEFAULT_IMG)
  ) u_active (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .image_i  (chain_q),
    .active_o (active_q)
  );

  assign image_o = mode_i ? DEFAULT_IMG : active_q;

  cfg_field_decode u_dec (
    .image_i       (image_o),
    .in_div_o      (in_div_o),
    .fb_div_o      (fb_div_o),
    .out_div_o     (out_div_o),
    .out_mux_o     (out_mux_o),
    .fb_sel_o      (fb_sel_o),
    .fb_dly_o      (fb_dly_o),
    .ext_dly_sel_o (ext_dly_sel_o),
    .out_dly_o     (out_dly_o),
    .vco_sel_o     (vco_sel_o),
    .rst_en_o      (rst_en_o),
    .half_div_o    (half_div_o),
    .gmux_cfg_o    (gmux_cfg_o)
  );
endmodule

// File: rtl/cfg_serial_chain_chk.sv
module cfg_serial_chain_chk
  import cfg_chain_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sdata_i,
  input logic             shift_i,
  input logic             update_i,
  input logic             mode_i,
  input logic             sdata_o,
  input logic [CFG_W-1:0] chain_i,
  input logic [CFG_W-1:0] active_i,
  input logic [CFG_W-1:0] image_i
);
  // R2
  shift_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> chain_i[0] == $past(sdata_i) && chain_i[CFG_W-1:1] == $past(chain_i[CFG_W-2:0]));

  // R3
  serial_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sdata_o == $past(chain_i[CFG_W-2]));

  // R4
  chain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(chain_i) && $stable(sdata_o));

  // R5
  update_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !shift_i) |=> active_i == ($past(chain_i) & USED_MASK));

  // R6
  update_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> $stable(active_i));

  // R7
  default_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> image_i == DEFAULT_IMG);

  // R9
  gap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (image_i & ~USED_MASK) == '0);
endmodule

bind cfg_serial_chain cfg_serial_chain_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sdata_i  (sdata_i),
  .shift_i  (shift_i),
  .update_i (update_i),
  .mode_i   (mode_i),
  .sdata_o  (sdata_o),
  .chain_i  (chain_q),
  .active_i (active_q),
  .image_i  (image_o)
);

// File: tb/cfg_serial_chain_bench.sv
module cfg_serial_chain_bench;
  logic clk = 1'b0;
  always #4ns clk = ~clk;  // 125 MHz

  logic rst_ni, sdata_i, shift_i, update_i, mode_i, sdata_o;
  logic [88:0] image_o;
  logic [6:0] in_div_o, fb_div_o;
  logic [2:0][4:0] out_div_o, out_dly_o;
  logic [2:0][2:0] out_mux_o;
  logic [1:0] fb_sel_o, gmux_cfg_o;
  logic [4:0] fb_dly_o;
  logic ext_dly_sel_o, rst_en_o;
  logic [2:0] vco_sel_o, half_div_o;

  cfg_serial_chain u_cfg_serial_chain (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata_i), .shift_i(shift_i),
    .update_i(update_i), .mode_i(mode_i), .sdata_o(sdata_o), .image_o(image_o),
    .in_div_o(in_div_o), .fb_div_o(fb_div_o), .out_div_o(out_div_o),
    .out_mux_o(out_mux_o), .fb_sel_o(fb_sel_o), .fb_dly_o(fb_dly_o),
    .ext_dly_sel_o(ext_dly_sel_o), .out_dly_o(out_dly_o), .vco_sel_o(vco_sel_o),
    .rst_en_o(rst_en_o), .half_div_o(half_div_o), .gmux_cfg_o(gmux_cfg_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit [88:0] m_sr = '0;
  bit exp_q[$];
  bit [88:0] mask, defimg;
  localparam bit [88:0] PAT = 89'h1_E75A_5AC3_C3F0_0F96_697E_81;

  task automatic chk(bit ok, string req, string what, logic [88:0] act, logic [88:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: one expected serial bit per shifting edge (R2, R3)
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      chk(sdata_o === e, "R3", "sdata_o stream", {88'd0, sdata_o}, {88'd0, e});
    end
  end

  task automatic shift_bit(bit b, bit upd);
    @(negedge clk);
    sdata_i = b; shift_i = 1'b1; update_i = upd;
    @(posedge clk);
    #1ns;
    m_sr = {m_sr[87:0], b};
    exp_q.push_back(m_sr[88]);
  endtask

  task automatic idle();
    @(negedge clk);
    shift_i = 1'b0; update_i = 1'b0;
  endtask

  task automatic do_update();
    @(negedge clk);
    shift_i = 1'b0; update_i = 1'b1;
    @(negedge clk);
    update_i = 1'b0;
  endtask

  task automatic check_fields(bit [88:0] e, string req);
    chk(image_o === e, req, "image_o", image_o, e);
    chk(in_div_o === e[6:0] && fb_div_o === e[13:7], "R8", "dividers",
        {75'd0, fb_div_o, in_div_o}, {75'd0, e[13:0]});
    for (int c = 0; c < 3; c++) begin
      chk(out_div_o[c] === e[14+5*c +: 5], "R8", "out_div", {84'd0, out_div_o[c]}, {84'd0, e[14+5*c +: 5]});
      chk(out_mux_o[c] === e[29+3*c +: 3], "R8", "out_mux", {86'd0, out_mux_o[c]}, {86'd0, e[29+3*c +: 3]});
      chk(out_dly_o[c] === e[46+5*c +: 5], "R8", "out_dly", {84'd0, out_dly_o[c]}, {84'd0, e[46+5*c +: 5]});
      chk(half_div_o[c] === e[84+c], "R8", "half_div", {88'd0, half_div_o[c]}, {88'd0, e[84+c]});
    end
    chk({fb_sel_o, fb_dly_o, ext_dly_sel_o, vco_sel_o, rst_en_o, gmux_cfg_o} ===
        {e[39:38], e[44:40], e[45], e[76:74], e[80], e[88:87]}, "R8", "misc fields",
        {74'd0, fb_sel_o, fb_dly_o, ext_dly_sel_o, vco_sel_o, rst_en_o, gmux_cfg_o},
        {74'd0, e[39:38], e[44:40], e[45], e[76:74], e[80], e[88:87]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    mask = '0;
    mask[60:0] = '1; mask[76:74] = '1; mask[80] = 1'b1; mask[88:84] = '1;
    defimg = '0;
    defimg[6:0] = 7'h12; defimg[13:7] = 7'h12; defimg[18:14] = 5'd1;
    defimg[31:29] = 3'd4; defimg[39:38] = 2'd1; defimg[45] = 1'b1;
    defimg[50:46] = 5'd3; defimg[55:51] = 5'd31; defimg[80] = 1'b1;

    rst_ni = 1'b0; sdata_i = 1'b0; shift_i = 1'b0; update_i = 1'b0; mode_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(sdata_o === 1'b0, "R1", "sdata_o in reset", {88'd0, sdata_o}, '0);
    check_fields(defimg, "R1");
    mode_i = 1'b1; #1ns;
    check_fields(defimg, "R10");
    mode_i = 1'b0;
    rst_ni = 1'b1;

    // R2/R3: load pattern, bit 88 first; shifting with mode high keeps built-in fields
    mode_i = 1'b1;
    for (int i = 88; i >= 0; i--) shift_bit(PAT[i], 1'b0);
    idle();
    check_fields(defimg, "R7");
    mode_i = 1'b0; #1ns;
    chk(image_o === defimg, "R5", "active untouched by shifting", image_o, defimg);

    do_update();
    check_fields(PAT & mask, "R5");
    chk((image_o & ~mask) === '0, "R9", "gap bits", image_o & ~mask, '0);
    mode_i = 1'b1; #1ns;
    check_fields(defimg, "R7");
    mode_i = 1'b0; #1ns;

    // R4: hold with shift low while sdata_i toggles
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      sdata_i = ~sdata_i;
      chk(sdata_o === m_sr[88], "R4", "sdata_o hold", {88'd0, sdata_o}, {88'd0, m_sr[88]});
    end
    do_update();
    check_fields(PAT & mask, "R4");

    // R6: shift and update on the same edge
    shift_bit(1'b1, 1'b1);
    idle();
    chk(image_o === (PAT & mask), "R6", "active kept on shared edge", image_o, PAT & mask);
    do_update();
    check_fields(m_sr & mask, "R6");

    // second pattern, inverted
    for (int i = 88; i >= 0; i--) shift_bit(~PAT[i], 1'b0);
    idle();
    do_update();
    check_fields(~PAT & mask, "R8");
    chk((image_o & ~mask) === '0, "R9", "gap bits inverted", image_o & ~mask, '0);

    // drain with zeros; stream shows the inverted pattern
    for (int i = 0; i < 89; i++) shift_bit(1'b0, 1'b0);
    idle();
    do_update();
    check_fields('0, "R2");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule